// File: doc/BRIEF.md
# Legacy UART host register interface

This block is the processor-facing side of a classic eight-register serial controller. A byte-wide register bus with a 3-bit offset reaches the control registers: interrupt enable, line control, modem control, scratch and a 16-bit baud divisor. The same bus reaches the read-only line status, interrupt identification and modem status views. Bit-level serialization sits outside the block. A data write hands the byte to that logic on a one-cycle strobe. Received bytes and break events come back through a ready/valid pair.

A single interrupt line reports the most urgent cause through a fixed-priority identification code. A held receive byte ranks above a transmit-empty notice. The transmit-empty notice lives in a hidden pending latch. Writing to the interrupt enable register arms the latch, and so does sending a byte. Reading the identification register while it shows the transmit code clears the latch. A loopback mode folds the modem-control outputs back into the modem-status read value, so software can test its modem handling without a cable.

Top module: `uart_host_if`

## Requirements
- R1: While reset is held and directly after it, the line status read (offset 5) is 0x60, the identification read (offset 2) is 0x01, the modem status read (offset 6) is 0xB0, irq is 0 and rx_ready is 1. Reset is synchronous and active high.
- R2: Bit 7 of the line control register (offset 3) is the divisor select. While it is set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The divisor appears on divisor_o. No transmit strobe is produced and the interrupt enable register is left unchanged.
- R3: A write to offset 1 with the divisor select clear stores only data bits 3:0, and reads return 0 in bits 7:4. Because the transmit-empty status bit (0x20) is set, the write also arms the transmit-pending latch.
- R4: The identification code is 0x04 when data-ready is set and enable bit 0 is set. Otherwise it is 0x02 when the transmit-pending latch is set and enable bit 1 is set. Otherwise it is 0x01. irq is 1 exactly when the code is not 0x01.
- R5: A read of offset 2 returns the current code. When that code is 0x02, the transmit-pending latch is clear from the next cycle onward. A read that returns 0x04 leaves the latch unchanged.
- R6: A write to offset 0 with the divisor select clear raises tx_valid in the same cycle, with tx_data equal to the written byte. It arms the transmit-pending latch and leaves status bits 0x20 and 0x40 set.
- R7: A read of offset 0 with the divisor select clear returns the held receive byte. From the next cycle on, data-ready (status bit 0x01) and break (status bit 0x10) are clear. The read data in the strobe cycle shows the value from before the update.
- R8: rx_ready is 1 only while data-ready is clear and no offset-0 data read is in progress. When rx_valid is accepted, the block stores rx_data and sets data-ready. When rx_break is accepted (it takes precedence over rx_valid), the block stores 0x00 and sets both break and data-ready. While rx_ready is 0, offered input is refused and the held byte is unchanged.
- R9: The modem control register (offset 4) keeps data bits 4:0, drives mctl_o and reads back with bits 7:5 at 0. When bit 4 (loopback) is set, the offset-6 read maps register bits 3:2 to read bits 7:6, bit 0 to read bit 5 and bit 1 to read bit 4. The other read bits are 0.
- R10: Outside loopback, the offset-6 read returns mstat_i as captured on the previous clock edge.
- R11: Offset 7 is a read/write scratch byte. The line control register reads back in full, and its bit 6 drives brk_o. Writes to offsets 2, 5 and 6 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset (combinational) |
| tx_valid | output | 1 | Byte handed to the transmitter this cycle |
| tx_data | output | 8 | Transmitted byte |
| rx_valid | input | 1 | Received byte offered |
| rx_break | input | 1 | Break event offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive holding slot can accept |
| irq | output | 1 | Interrupt request |
| mctl_o | output | 5 | Modem control register bits |
| brk_o | output | 1 | Break control to the line |
| mstat_i | input | 8 | Modem status inputs |
| divisor_o | output | 16 | Baud divisor latch value |

## Verification
The interrupt priority is driven with four enable masks against every mix of held receive byte and transmit-pending latch. Each mix shows whether the receive cause really overrides the transmit cause, and whether a read that returns the receive code leaves the latch alone. Receive traffic is offered in three ways: into an empty slot, into a full slot, and in the same cycle as a data read. These three separate the acceptance rule from the ordering between read and receive. A break event then shows the zero byte and the extra status bit. Two loopback patterns with complementary bit positions expose any swapped mapping. Divisor-select writes show the aliasing of offsets 0 and 1 and the absence of a transmit strobe.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int IEW  = 4;
    localparam int MCW  = 5;
    localparam int DIVW = 2 * DW;

    typedef enum logic [AW-1:0] {
        OFS_DATA    = 3'd0,
        OFS_IEN     = 3'd1,
        OFS_IDENT   = 3'd2,
        OFS_LCTL    = 3'd3,
        OFS_MCTL    = 3'd4,
        OFS_LSTAT   = 3'd5,
        OFS_MSTAT   = 3'd6,
        OFS_SCRATCH = 3'd7
    } ofs_e;

    localparam logic [DW-1:0] ID_RX   = 8'h04;
    localparam logic [DW-1:0] ID_TX   = 8'h02;
    localparam logic [DW-1:0] ID_NONE = 8'h01;
    localparam logic [DW-1:0] MSTAT_RESET = 8'hB0;

    localparam int LCTL_DIVSEL = 7;
    localparam int LCTL_BRK    = 6;
    localparam int MCTL_LOOP   = 4;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic div_lo_wr;
        logic div_hi_wr;
        logic ien_wr;
        logic ident_rd;
        logic lctl_wr;
        logic mctl_wr;
        logic scr_wr;
    } acc_t;

    function automatic acc_t decode_access(input logic [AW-1:0] ofs, input logic wr,
                                           input logic rd, input logic divsel);
        acc_t a;
        a = '0;
        case (ofs_e'(ofs))
            OFS_DATA: begin
                a.data_wr   = wr && !divsel;
                a.div_lo_wr = wr && divsel;
                a.data_rd   = rd && !divsel;
            end
            OFS_IEN: begin
                a.ien_wr    = wr && !divsel;
                a.div_hi_wr = wr && divsel;
            end
            OFS_IDENT:   a.ident_rd = rd;
            OFS_LCTL:    a.lctl_wr  = wr;
            OFS_MCTL:    a.mctl_wr  = wr;
            OFS_SCRATCH: a.scr_wr   = wr;
            default: ;
        endcase
        return a;
    endfunction

    function automatic logic [DW-1:0] ident_code(input logic dr, input logic en_rx,
                                                 input logic pend, input logic en_tx);
        if (dr && en_rx)        return ID_RX;
        else if (pend && en_tx) return ID_TX;
        else                    return ID_NONE;
    endfunction

    function automatic logic [DW-1:0] loop_view(input logic [MCW-1:0] m);
        return {m[3], m[2], m[0], m[1], 4'b0000};
    endfunction

endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_host_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   wdata,
    input  logic            data_wr,
    input  logic            div_lo_wr,
    input  logic            div_hi_wr,
    input  logic            ien_wr,
    input  logic            lctl_wr,
    input  logic            mctl_wr,
    input  logic            scr_wr,
    output logic [IEW-1:0]  ien,
    output logic [DW-1:0]   lctl,
    output logic [MCW-1:0]  mctl,
    output logic [DW-1:0]   scr,
    output logic [DIVW-1:0] divisor,
    output logic            thr_empty,
    output logic            tx_idle
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien       <= '0;
            lctl      <= '0;
            mctl      <= '0;
            scr       <= '0;
            divisor   <= '0;
            thr_empty <= 1'b1;
            tx_idle   <= 1'b1;
        end else begin
            if (ien_wr)    ien <= wdata[IEW-1:0];
            if (lctl_wr)   lctl <= wdata;
            if (mctl_wr)   mctl <= wdata[MCW-1:0];
            if (scr_wr)    scr <= wdata;
            if (div_lo_wr) divisor[DW-1:0] <= wdata;
            if (div_hi_wr) divisor[DIVW-1:DW] <= wdata;
            if (data_wr) begin
                thr_empty <= 1'b1;
                tx_idle   <= 1'b1;
            end
        end
    end

    // R2: divisor only moves on a divisor-select write
    a_r2_div_hold: assert property (@(posedge clk) disable iff (rst)
        !(div_lo_wr || div_hi_wr) |=> $stable(divisor));

    // R3: enable register only moves on its own write
    a_r3_ien_hold: assert property (@(posedge clk) disable iff (rst)
        !ien_wr |=> $stable(ien));

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic          rx_break,
    input  logic [DW-1:0] rx_data,
    input  logic          data_rd,
    output logic          rx_ready,
    output logic [DW-1:0] rbr,
    output logic          dr,
    output logic          bi
);

    logic accept;

    assign rx_ready = !dr && !data_rd;
    assign accept   = (rx_valid || rx_break) && rx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr <= '0;
            dr  <= 1'b0;
            bi  <= 1'b0;
        end else begin
            if (data_rd) begin
                dr <= 1'b0;
                bi <= 1'b0;
            end
            if (accept) begin
                rbr <= rx_break ? '0 : rx_data;
                dr  <= 1'b1;
                if (rx_break) bi <= 1'b1;
            end
        end
    end

    // R8: a held byte is never overwritten
    a_r8_hold_full: assert property (@(posedge clk) disable iff (rst)
        dr |=> $stable(rbr));

    // R7: a data read always empties the slot
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> (!dr && !bi));

    // R8: break flag never set without data-ready
    a_r8_break_implies_ready: assert property (@(posedge clk) disable iff (rst)
        bi |-> dr);

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          dr,
    input  logic [1:0]    ien_lo,
    input  logic          arm,
    input  logic          ident_rd,
    output logic [DW-1:0] ident,
    output logic          irq,
    output logic          tx_pend
);

    assign ident = ident_code(dr, ien_lo[0], tx_pend, ien_lo[1]);
    assign irq   = (ident != ID_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_pend <= 1'b0;
        end else if (arm) begin
            tx_pend <= 1'b1;
        end else if (ident_rd && ident == ID_TX) begin
            tx_pend <= 1'b0;
        end
    end

    // R5: reading the transmit code drops the latch
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (ident_rd && ident == ID_TX && !arm) |=> !tx_pend);

    // R5: reading the receive code keeps the latch
    a_r5_rx_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (ident_rd && ident == ID_RX) |=> (tx_pend == $past(tx_pend)));

endmodule

// File: rtl/uart_modem_view.sv
module uart_modem_view
    import uart_host_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  mstat_i,
    input  logic [MCW-1:0] mctl,
    output logic [DW-1:0]  view
);

    logic [DW-1:0] msr_q;

    always_ff @(posedge clk) begin
        if (rst) msr_q <= MSTAT_RESET;
        else     msr_q <= mstat_i;
    end

    assign view = mctl[MCTL_LOOP] ? loop_view(mctl) : msr_q;

    // R10: captured status tracks the inputs one edge late
    a_r10_capture: assert property (@(posedge clk) disable iff (rst)
        !$stable(mstat_i) |=> (msr_q == $past(mstat_i)));

endmodule

// File: rtl/uart_host_if.sv
module uart_host_if
    import uart_host_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            tx_valid,
    output logic [DW-1:0]   tx_data,
    input  logic            rx_valid,
    input  logic            rx_break,
    input  logic [DW-1:0]   rx_data,
    output logic            rx_ready,
    output logic            irq,
    output logic [MCW-1:0]  mctl_o,
    output logic            brk_o,
    input  logic [DW-1:0]   mstat_i,
    output logic [DIVW-1:0] divisor_o
);

    acc_t           acc;
    logic [IEW-1:0] ien;
    logic [DW-1:0]  lctl;
    logic [MCW-1:0] mctl;
    logic [DW-1:0]  scr;
    logic           thr_empty;
    logic           tx_idle;
    logic [DW-1:0]  rbr;
    logic           dr;
    logic           bi;
    logic [DW-1:0]  ident;
    logic           tx_pend;
    logic [DW-1:0]  mview;
    logic           arm;
    logic           divsel;

    assign divsel = lctl[LCTL_DIVSEL];
    assign acc    = decode_access(bus_addr, bus_wr, bus_rd, divsel);
    assign arm    = acc.data_wr || (acc.ien_wr && thr_empty);

    uart_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wdata     (bus_wdata),
        .data_wr   (acc.data_wr),
        .div_lo_wr (acc.div_lo_wr),
        .div_hi_wr (acc.div_hi_wr),
        .ien_wr    (acc.ien_wr),
        .lctl_wr   (acc.lctl_wr),
        .mctl_wr   (acc.mctl_wr),
        .scr_wr    (acc.scr_wr),
        .ien       (ien),
        .lctl      (lctl),
        .mctl      (mctl),
        .scr       (scr),
        .divisor   (divisor_o),
        .thr_empty (thr_empty),
        .tx_idle   (tx_idle)
    );

    uart_rx_hold u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_break (rx_break),
        .rx_data  (rx_data),
        .data_rd  (acc.data_rd),
        .rx_ready (rx_ready),
        .rbr      (rbr),
        .dr       (dr),
        .bi       (bi)
    );

    uart_irq_id u_irq (
        .clk      (clk),
        .rst      (rst),
        .dr       (dr),
        .ien_lo   (ien[1:0]),
        .arm      (arm),
        .ident_rd (acc.ident_rd),
        .ident    (ident),
        .irq      (irq),
        .tx_pend  (tx_pend)
    );

    uart_modem_view u_modem (
        .clk     (clk),
        .rst     (rst),
        .mstat_i (mstat_i),
        .mctl    (mctl),
        .view    (mview)
    );

    always_comb begin
        case (ofs_e'(bus_addr))
            OFS_DATA:    bus_rdata = divsel ? divisor_o[DW-1:0] : rbr;
            OFS_IEN:     bus_rdata = divsel ? divisor_o[DIVW-1:DW] : {{(DW-IEW){1'b0}}, ien};
            OFS_IDENT:   bus_rdata = ident;
            OFS_LCTL:    bus_rdata = lctl;
            OFS_MCTL:    bus_rdata = {{(DW-MCW){1'b0}}, mctl};
            OFS_LSTAT:   bus_rdata = {1'b0, tx_idle, thr_empty, bi, 3'b000, dr};
            OFS_MSTAT:   bus_rdata = mview;
            default:     bus_rdata = scr;
        endcase
    end

    assign tx_valid = acc.data_wr;
    assign tx_data  = bus_wdata;
    assign mctl_o   = mctl;
    assign brk_o    = lctl[LCTL_BRK];

    // R4: enabled held byte always raises the line
    a_r4_rx_irq: assert property (@(posedge clk) disable iff (rst)
        (dr && ien[0]) |-> irq);

    // R4: no enabled cause means a quiet line
    a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
        ((!dr || !ien[0]) && (!tx_pend || !ien[1])) |-> !irq);

    // R6: sending a byte arms the transmit notice
    a_r6_tx_arms: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_pend);

    // R8: receive slot never offered while a data read is on the bus
    a_r8_no_ready_on_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd0 && !divsel) |-> !rx_ready);

endmodule

// File: tb/sim_uart_host_if.sv
`timescale 1ns/100ps
module sim_uart_host_if;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0;
    logic       rx_break = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       irq;
    logic [4:0] mctl_o;
    logic       brk_o;
    logic [7:0] mstat_i = 8'hB0;
    logic [15:0] divisor_o;

    always #2 clk = ~clk;

    uart_host_if u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data), .rx_ready(rx_ready),
        .irq(irq), .mctl_o(mctl_o), .brk_o(brk_o), .mstat_i(mstat_i), .divisor_o(divisor_o)
    );

    int total = 0;
    int bad = 0;
    bit running = 0;
    bit finished = 0;

    // behavioural model state
    bit         m_dr = 0, m_bi = 0, m_pend = 0;
    logic [7:0] m_rbr = 0, m_lcr = 0, m_scr = 0, m_msr = 8'hB0;
    logic [3:0] m_ier = 0;
    logic [4:0] m_mcr = 0;
    logic [15:0] m_div = 0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_code();
        if (m_dr && m_ier[0])        return 8'h04;
        else if (m_pend && m_ier[1]) return 8'h02;
        else                         return 8'h01;
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? m_div[7:0] : m_rbr;
            3'd1: return m_lcr[7] ? m_div[15:8] : {4'h0, m_ier};
            3'd2: return m_code();
            3'd3: return m_lcr;
            3'd4: return {3'b000, m_mcr};
            3'd5: return {1'b0, 1'b1, 1'b1, m_bi, 3'b000, m_dr};
            3'd6: return m_mcr[4] ? {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1], 4'h0} : m_msr;
            default: return m_scr;
        endcase
    endfunction

    // every clock: interrupt line and receive readiness against the model
    always @(posedge clk) begin
        #1.5;
        if (running) begin
            check("R4 irq", irq, (m_code() != 8'h01));
            check("R8 rx_ready", rx_ready, !m_dr);
        end
    end

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        if (a == 3'd0 && !m_lcr[7]) begin
            check("R6 tx_valid", tx_valid, 1'b1);
            check("R6 tx_data", tx_data, d);
        end else begin
            check("R2 no tx strobe", tx_valid, 1'b0);
        end
        @(posedge clk); #1;
        bus_wr = 1'b0;
        case (a)
            3'd0: if (m_lcr[7]) m_div[7:0] = d; else m_pend = 1;
            3'd1: if (m_lcr[7]) m_div[15:8] = d; else begin m_ier = d[3:0]; m_pend = 1; end
            3'd3: m_lcr = d;
            3'd4: m_mcr = d[4:0];
            3'd7: m_scr = d;
            default: ;
        endcase
    endtask

    task automatic do_read(input string tag, input logic [2:0] a);
        logic [7:0] exp;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp = m_read(a);
        #1;
        check(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 1'b0;
        if (a == 3'd0 && !m_lcr[7]) begin m_dr = 0; m_bi = 0; end
        if (a == 3'd2 && exp == 8'h02) m_pend = 0;
    endtask

    task automatic rx_push(input logic [7:0] d, input bit brk);
        @(negedge clk);
        rx_valid = !brk; rx_break = brk; rx_data = d;
        #1;
        check("R8 offer ready", rx_ready, !m_dr);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_break = 1'b0;
        if (!m_dr) begin
            m_rbr = brk ? 8'h00 : d;
            m_dr = 1;
            if (brk) m_bi = 1;
        end
    endtask

    task automatic read_with_rx(input logic [7:0] d);
        logic [7:0] exp;
        @(negedge clk);
        bus_addr = 3'd0; bus_rd = 1'b1; rx_valid = 1'b1; rx_data = d;
        exp = m_read(3'd0);
        #1;
        check("R7 read data pre-update", bus_rdata, exp);
        check("R8 refused during read", rx_ready, 1'b0);
        @(posedge clk); #1;
        bus_rd = 1'b0; rx_valid = 1'b0;
        m_dr = 0; m_bi = 0;
    endtask

    task automatic set_mstat(input logic [7:0] v);
        @(negedge clk);
        mstat_i = v;
        @(posedge clk); #1;
        m_msr = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values while reset is held
        bus_addr = 3'd5; #0.2; check("R1 line status", bus_rdata, 8'h60);
        bus_addr = 3'd2; #0.2; check("R1 ident", bus_rdata, 8'h01);
        bus_addr = 3'd6; #0.2; check("R1 modem status", bus_rdata, 8'hB0);
        check("R1 irq", irq, 1'b0);
        check("R1 rx_ready", rx_ready, 1'b1);
        rst = 1'b0;
        @(posedge clk); #1;
        running = 1;
        do_read("R1 line status after reset", 3'd5);

        // R11: scratch, line control, ignored writes
        do_write(3'd7, 8'hA5);
        do_read("R11 scratch", 3'd7);
        do_write(3'd3, 8'h03);
        do_read("R11 line control", 3'd3);
        do_write(3'd5, 8'h00);
        do_read("R11 status unchanged by write", 3'd5);
        do_write(3'd2, 8'hFF);
        do_read("R11 ident unchanged by write", 3'd2);
        do_write(3'd6, 8'h00);
        do_read("R11 modem status unchanged by write", 3'd6);

        // R3 / R5: enable write arms, ident read clears
        do_write(3'd1, 8'hFF);
        do_read("R3 enable masked", 3'd1);
        do_read("R5 ident shows tx", 3'd2);
        do_read("R5 ident after clear", 3'd2);

        // R6: data write
        do_write(3'd0, 8'h5A);
        do_read("R6 status after send", 3'd5);
        do_read("R6 ident after send", 3'd2);

        // R4: priority with both causes
        do_write(3'd1, 8'h03);
        rx_push(8'h3C, 0);
        do_read("R4 rx over tx", 3'd2);
        do_read("R7 status with byte", 3'd5);
        rx_push(8'h99, 0);
        do_read("R7 data byte", 3'd0);
        do_read("R5 tx kept after rx code", 3'd2);
        do_read("R7 status cleared", 3'd5);

        // R4: masks
        do_write(3'd1, 8'h02);
        rx_push(8'h11, 0);
        do_read("R4 rx masked shows tx", 3'd2);
        do_write(3'd1, 8'h00);
        do_read("R4 all masked", 3'd2);
        do_write(3'd1, 8'h01);
        do_read("R4 rx only", 3'd2);

        // R8: read and receive in the same cycle
        read_with_rx(8'h77);
        do_read("R8 slot empty after collision", 3'd5);
        rx_push(8'h78, 0);
        do_read("R8 next byte accepted", 3'd0);

        // R8: break
        rx_push(8'hEE, 1);
        do_read("R8 break status", 3'd5);
        do_read("R8 break byte", 3'd0);
        do_read("R7 break cleared", 3'd5);

        // R2: divisor select
        do_write(3'd1, 8'h05);
        do_write(3'd3, 8'h83);
        do_write(3'd0, 8'h34);
        do_write(3'd1, 8'h12);
        #0.5; check("R2 divisor_o", divisor_o, 16'h1234);
        do_read("R2 divisor low", 3'd0);
        do_read("R2 divisor high", 3'd1);
        do_write(3'd3, 8'h03);
        do_read("R2 enable untouched", 3'd1);
        do_write(3'd0, 8'hC3);

        // R9: modem control and loopback
        do_write(3'd4, 8'hEF);
        #0.5; check("R9 mctl_o", mctl_o, 5'h0F);
        do_read("R9 modem control read", 3'd4);
        do_write(3'd4, 8'h15);
        do_read("R9 loopback map A", 3'd6);
        do_write(3'd4, 8'h1A);
        do_read("R9 loopback map B", 3'd6);

        // R10: live modem status
        do_write(3'd4, 8'h00);
        set_mstat(8'h5F);
        do_read("R10 modem status", 3'd6);

        // R11: break control
        do_write(3'd3, 8'h40);
        #0.5; check("R11 brk_o set", brk_o, 1'b1);
        do_write(3'd3, 8'h00);
        #0.5; check("R11 brk_o clear", brk_o, 1'b0);

        repeat (4) @(posedge clk);
        #1;
        running = 0;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule